// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block is a 32-bit timer that counts down. It sits behind a small synchronous register bus and has a 32-byte window. Software programs a reload value, an 8-bit prescaler, an enable bit and an auto-reload bit. The counter then steps down once every (P+1) clock cycles. When it reaches zero, a sticky status flag is set, and that flag drives a level interrupt directly.

In one-shot mode the count stays at zero after an expiry. In auto-reload mode the count is refilled from the reload register and keeps running. Software clears the flag by writing a one to the status register. The same block can serve as a per-core watchdog when used as a plain timer.

Top module: `prescaled_downtimer`

## Requirements
- R1: Four word registers are decoded from the 5-bit address: 0x00 reload value, 0x04 live count, 0x08 control, 0x0C status. The read data reflects the addressed register combinationally, and a write takes effect at the clock edge where `sel` and `we` are high.
- R2: In the control register, bit 0 is enable, bit 1 is auto-reload and bits 15:8 are the prescaler P. All other bits are not stored and read back as zero.
- R3: While the timer is enabled with a nonzero count, the count decrements once every P+1 cycles. A count of N written (or enabled) at edge E reaches zero at edge E+N·(P+1).
- R4: A write to 0x00 sets both the reload value and the count. A write to 0x04 sets only the count and leaves the reload value unchanged. Either write restarts the prescale phase.
- R5: When the count steps from 1 to 0, status bit 0 is set. Without auto-reload the count then stays at zero.
- R6: With auto-reload set, an expiry refills the count from the reload value in the same edge, and counting continues. The next expiry follows after the full reload period.
- R7: A control write that raises enable while the count is zero and the written auto-reload bit is 1 copies the reload value into the count.
- R8: An enabled timer whose count is zero never sets status and never changes its count.
- R9: Reading 0x04 returns zero while enable is 0 or the count is zero. Otherwise it returns the remaining count.
- R10: A write to 0x0C with data bit 0 equal to 1 clears the status flag. The `irq` output always equals the status flag.
- R11: Reset clears the reload value, count, control and status. Reads from offsets other than the four registers return zero, and writes to them change nothing.
- R12: A bus write to 0x00 or 0x04 in the same edge as an expiry wins over the auto-reload refill. The status flag is still set in that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register access select |
| we | input | 1 | Write enable, qualified by sel |
| addr | input | 5 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
The countdown is exercised in four ways:
- One-shot with a prescaler of 2. This separates a correct period of N·(P+1) from off-by-one errors in both the prescaler and the count.
- Auto-reload with no prescaling. This shows whether the refill happens in the expiry edge and whether the second period has full length.
- Enable with a zero count, once with auto-reload and once without. This distinguishes the copy from the reload value from the rule that a zero count never fires.
- A counter write placed exactly on an expiry edge. This tells apart the write-wins priority from the refill, while the flag is still set.

// File: rtl/prescaled_downtimer.sv
module prescaled_downtimer #(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_LOAD = AW'(5'h00);
  localparam logic [AW-1:0] OFS_CNT  = AW'(5'h04);
  localparam logic [AW-1:0] OFS_CTRL = AW'(5'h08);
  localparam logic [AW-1:0] OFS_STAT = AW'(5'h0C);
  localparam int PLO = 8;

  logic [DW-1:0] load_q, count_q;
  logic [PW-1:0] psc_q, pre_q;
  logic          en_q, arl_q, stat_q;

  wire wr      = sel && we;
  wire wr_load = wr && addr == OFS_LOAD;
  wire wr_cnt  = wr && addr == OFS_CNT;
  wire wr_ctrl = wr && addr == OFS_CTRL;
  wire wr_stat = wr && addr == OFS_STAT;
  wire en_rise = wr_ctrl && wdata[0] && !en_q;
  wire run     = en_q && count_q != '0;
  wire tick    = run && pre_q == psc_q;
  wire expire  = tick && count_q == DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
      pre_q   <= '0;
      psc_q   <= '0;
      en_q    <= 1'b0;
      arl_q   <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;

      if (wr_load || wr_cnt)
        count_q <= wdata;
      else if (en_rise && count_q == '0 && wdata[1])
        count_q <= load_q;
      else if (tick)
        count_q <= (count_q == DW'(1)) ? (arl_q ? load_q : '0) : count_q - DW'(1);

      if (wr_load || wr_cnt || en_rise || !run || tick)
        pre_q <= '0;
      else
        pre_q <= pre_q + PW'(1);

      if (wr_ctrl) begin
        en_q  <= wdata[0];
        arl_q <= wdata[1];
        psc_q <= wdata[PLO +: PW];
      end

      stat_q <= expire || (stat_q && !(wr_stat && wdata[0]));
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_LOAD: rdata = load_q;
      OFS_CNT:  rdata = run ? count_q : '0;
      OFS_CTRL: begin
        rdata[0]        = en_q;
        rdata[1]        = arl_q;
        rdata[PLO +: PW] = psc_q;
      end
      OFS_STAT: rdata[0] = stat_q;
      default:  rdata = '0;
    endcase
  end

  assign irq = stat_q;
endmodule

// File: rtl/prescaled_downtimer_chk.sv
module prescaled_downtimer_chk #(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic [DW-1:0] count_q,
  input logic [DW-1:0] load_q,
  input logic [PW-1:0] pre_q,
  input logic [PW-1:0] psc_q,
  input logic          en_q
);
  wire bus_wr = sel && we;

  AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !bus_wr) |=> count_q == '0); // R8
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && count_q != '0 && pre_q != psc_q && !bus_wr) |=> $stable(count_q)); // R3
  AST_LOAD_WRITES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr == AW'(0)) |=> (count_q == $past(wdata) && load_q == $past(wdata))); // R4
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr == AW'(12) && wdata[0] && count_q != DW'(1)) |=> !irq); // R10
  AST_DISABLED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(4) && !en_q) |-> rdata == '0); // R9
  AST_IRQ_FROM_LAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(count_q) == DW'(1)); // R5
endmodule

bind prescaled_downtimer prescaled_downtimer_chk #(.DW(DW), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .count_q(count_q), .load_q(load_q),
  .pre_q(pre_q), .psc_q(psc_q), .en_q(en_q)
);

// File: tb/test_prescaled_downtimer.sv
module test_prescaled_downtimer;
  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08, A_STAT = 5'h0C;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, we = 1'b0, irq;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prescaled_downtimer i_prescaled_downtimer (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 check(req, rdata, exp);
    sel = 1'b0;
  endtask

  task automatic wait_n(input int m);
    repeat (m) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R11 load", A_LOAD, 0);
    rd_chk("R11 count", A_CNT, 0);
    rd_chk("R11 ctrl", A_CTRL, 0);
    rd_chk("R11 status", A_STAT, 0);
    check("R11 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl_fields;
    bus_wr(A_CTRL, 32'hFFFF_00FC);
    rd_chk("R2 unused bits", A_CTRL, 0);
    bus_wr(A_CTRL, 32'h0000_AB02);
    rd_chk("R2 fields", A_CTRL, 32'h0000_AB02);
  endtask

  task automatic t_undefined;
    bus_wr(5'h10, 32'hFFFF_FFFF);
    bus_wr(5'h1C, 32'hFFFF_FFFF);
    rd_chk("R11 undef read", 5'h10, 0);
    rd_chk("R11 ctrl kept", A_CTRL, 32'h0000_AB02);
    rd_chk("R11 load kept", A_LOAD, 0);
    rd_chk("R1 status offset", A_STAT, 0);
  endtask

  task automatic t_oneshot;
    bus_wr(A_CTRL, 32'h0000_0201);
    bus_wr(A_LOAD, 4);
    rd_chk("R4 count from load", A_CNT, 4);
    rd_chk("R1 load offset", A_LOAD, 4);
    wait_n(2);
    rd_chk("R3 no step before P+1", A_CNT, 4);
    wait_n(1);
    rd_chk("R3 first step", A_CNT, 3);
    wait_n(8);
    check("R3 not yet expired", {31'b0, irq}, 0);
    wait_n(1);
    check("R5 expiry irq", {31'b0, irq}, 1);
    rd_chk("R5 status set", A_STAT, 1);
    rd_chk("R5 one-shot at zero", A_CNT, 0);
    wait_n(10);
    rd_chk("R9 zero count reads zero", A_CNT, 0);
  endtask

  task automatic t_clear;
    bus_wr(A_STAT, 0);
    check("R10 write zero keeps flag", {31'b0, irq}, 1);
    bus_wr(A_STAT, 1);
    check("R10 clear", {31'b0, irq}, 0);
  endtask

  task automatic t_autoreload;
    bus_wr(A_CTRL, 0);
    bus_wr(A_LOAD, 3);
    bus_wr(A_CTRL, 32'h0000_0003);
    wait_n(2);
    check("R3 auto before expiry", {31'b0, irq}, 0);
    wait_n(1);
    check("R6 first expiry", {31'b0, irq}, 1);
    rd_chk("R6 refilled", A_CNT, 3);
    bus_wr(A_STAT, 1);
    check("R10 irq follows clear", {31'b0, irq}, 0);
    wait_n(1);
    check("R6 second period running", {31'b0, irq}, 0);
    wait_n(1);
    check("R6 second expiry", {31'b0, irq}, 1);
  endtask

  task automatic t_zero_enable;
    bus_wr(A_CTRL, 0);
    bus_wr(A_CNT, 0);
    rd_chk("R4 count write keeps load", A_LOAD, 3);
    bus_wr(A_CTRL, 32'h0000_0003);
    rd_chk("R7 copy on enable", A_CNT, 3);
    bus_wr(A_CTRL, 0);
    bus_wr(A_CNT, 0);
    bus_wr(A_STAT, 1);
    bus_wr(A_CTRL, 32'h0000_0001);
    wait_n(20);
    check("R8 zero never fires", {31'b0, irq}, 0);
    rd_chk("R8 count stays zero", A_CNT, 0);
  endtask

  task automatic t_disabled_read;
    bus_wr(A_CTRL, 0);
    bus_wr(A_CNT, 7);
    rd_chk("R9 disabled reads zero", A_CNT, 0);
    bus_wr(A_CTRL, 32'h0000_0F01);
    rd_chk("R9 enabled reads count", A_CNT, 7);
  endtask

  task automatic t_collision;
    bus_wr(A_CTRL, 0);
    bus_wr(A_STAT, 1);
    bus_wr(A_LOAD, 2);
    bus_wr(A_CTRL, 32'h0000_0003);
    wait_n(1);
    bus_wr(A_CNT, 9);
    rd_chk("R12 write wins refill", A_CNT, 9);
    rd_chk("R12 status still set", A_STAT, 1);
    rd_chk("R12 load kept", A_LOAD, 2);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_ctrl_fields();
    t_undefined();
    t_oneshot();
    t_clear();
    t_autoreload();
    t_zero_enable();
    t_disabled_read();
    t_collision();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule